// File: doc/BRIEF.md
# Floppy Sector Access and Seek Sequencer

This block runs the medium side of sector commands for a two-drive, 77-track floppy controller. A register front end hands it a function code, drive, track and sector. The block waits out a seek whose length depends on how far the head must travel. It then checks the address against the geometry and the drive's presence and protection inputs. If the address is good, it moves one 128-byte sector between a byte-addressed sector memory and the controller's sector buffer. When it finishes, it returns a status byte, an error code and a one-cycle completion strobe.

The same block also runs the initialize sequence. Drive 0's head is parked on track 1 and drive 1's head on track 0. Track 1, sector 1 of drive 0 is then copied into the buffer, and the initialize-done status flag is set. The sector memory and the buffer both have a synchronous port with one cycle of read latency.

Top module: `flop_sect_seq`

## Requirements
- R1: Function 0 (read) copies 128 bytes from memory byte address (track*26 + sector - 1)*128 + i, on the selected drive (`mem_drive`), into buffer index i, for i = 0..127.
- R2: Function 1 (write) issues exactly 128 memory writes, each carrying buffer byte i to address (track*26 + sector - 1)*128 + i on the selected drive.
- R3: The completion delay grows by SEEK_CYC cycles for each track between the requested track and the drive's current head track. A drive's head track is updated only when the drive has medium and the requested track is below 77.
- R4: Each error completes with `fail`=1 and no memory access. The codes are octal 0110 for no medium, 040 for a track of 77 or more, and 070 for a sector of 0 or above 26. Function 1 or 2 on a protected drive gives octal 0100 and also sets status bit 3 (octal 010).
- R5: When several checks fail, only the first is reported, in the order medium presence, track, sector, write protection.
- R6: Accepting function 0, 1 or 2 clears every status bit except bit 2 (octal 004). At every completion, status bit 7 (octal 0200) equals the medium-present input of the selected drive.
- R7: Function 2 (write deleted) writes like function 1. On success it also sets status bit 6 (octal 0100).
- R8: A pulse on `init_req` aborts any running work and places drive 0 at track 1 and drive 1 at track 0. It then loads drive 0, track 1, sector 1 into the buffer and completes with status bit 2 set. The code is 0, or octal 020 with `fail`=0 when drive 1 has no medium.
- R9: If drive 0 has no medium during initialization, the sequence completes with status bit 2 set, code octal 010, `fail`=1 and no memory access.
- R10: `cmd_valid` is ignored while `busy` is high, and function code 3 is always ignored.
- R11: `done` is a single-cycle pulse. `err_code`, `fail` and `status` hold the result of that completion from the `done` cycle until the next completion.
- R12: After reset, `busy`, `done`, `fail`, `status` and `err_code` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_req | input | 1 | Start the initialize sequence (aborts any work) |
| cmd_valid | input | 1 | Command strobe, accepted only when idle |
| cmd_func | input | 2 | 0 read, 1 write, 2 write deleted, 3 ignored |
| cmd_drive | input | DRV_W | Drive select |
| cmd_track | input | 8 | Requested track |
| cmd_sector | input | 7 | Requested sector |
| drv_present | input | DRIVES | Medium present, one bit per drive |
| drv_wprot | input | DRIVES | Write protected, one bit per drive |
| mem_en | output | 1 | Sector memory access |
| mem_we | output | 1 | Sector memory write |
| mem_drive | output | DRV_W | Drive addressed by the memory access |
| mem_addr | output | ADDR_W | Linear byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after the access |
| buf_en | output | 1 | Sector buffer access |
| buf_we | output | 1 | Sector buffer write |
| buf_idx | output | IDX_W | Sector buffer byte index |
| buf_wdata | output | 8 | Buffer write data |
| buf_rdata | input | 8 | Buffer read data, one cycle after the access |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Completion strobe |
| fail | output | 1 | Completion ended in error |
| status | output | 8 | Status flags |
| err_code | output | 8 | Error code of the last completion |

## Verification
Seek timing is measured as a difference of completion latencies, so a design that ignores distance, or measures it from a stale head, gives the wrong difference. The head must stay put after a rejected track; a sequencer that moves it anyway shows a seek on the next same-track command. Failures are stacked two at a time in every adjacent pair of the check order, so a reordered chain reports the wrong code. The transfer is checked for both sector boundaries (sector 26 on track 76, and sectors 0 and 27), for one write per byte, and for byte ordering through the one-cycle memory and buffer latencies. The tests also cover a command arriving mid-transfer, which must not start a second operation, and initialization with each drive absent, which must give the right code, fail flag and ready flag.

// File: rtl/fss_pkg.sv
package fss_pkg;
  localparam int TRACKS = 77;
  localparam int SECTORS = 26;
  localparam int BYTES = 128;
  localparam int DRIVES = 2;
  localparam int DRV_W = (DRIVES > 1) ? $clog2(DRIVES) : 1;
  localparam int IDX_W = $clog2(BYTES);
  localparam int ADDR_W = $clog2(TRACKS * SECTORS * BYTES);

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_WRDEL = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  // completion codes (octal)
  localparam logic [7:0] EC_NONE    = 8'o000;
  localparam logic [7:0] EC_INIT0   = 8'o010;
  localparam logic [7:0] EC_INIT1   = 8'o020;
  localparam logic [7:0] EC_TRACK   = 8'o040;
  localparam logic [7:0] EC_SECTOR  = 8'o070;
  localparam logic [7:0] EC_WPROT   = 8'o100;
  localparam logic [7:0] EC_NOMEDIA = 8'o110;

  // status flags (octal)
  localparam logic [7:0] ST_CRC  = 8'o001;
  localparam logic [7:0] ST_PAR  = 8'o002;
  localparam logic [7:0] ST_INIT = 8'o004;
  localparam logic [7:0] ST_WLK  = 8'o010;
  localparam logic [7:0] ST_DEL  = 8'o100;
  localparam logic [7:0] ST_RDY  = 8'o200;

  // first byte of a sector in the linear image of one drive
  function automatic logic [ADDR_W-1:0] sector_base(input logic [7:0] trk,
                                                    input logic [6:0] sec);
    int lin;
    lin = (int'(trk) * SECTORS + int'(sec) - 1) * BYTES;
    return ADDR_W'(lin);
  endfunction

  // head travel in tracks
  function automatic logic [7:0] track_gap(input logic [7:0] a, input logic [7:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction
endpackage

// File: rtl/fss_addr_check.sv
module fss_addr_check
  import fss_pkg::*;
(
  input  logic       present,
  input  logic       wprot,
  input  logic       is_write,
  input  logic [7:0] trk,
  input  logic [6:0] sec,
  output logic [7:0] code,
  output logic       trk_ok
);
  logic trk_bad, sec_bad;

  assign trk_bad = (trk >= 8'(TRACKS));
  assign sec_bad = (sec == 7'd0) || (sec > 7'(SECTORS));
  assign trk_ok  = present && !trk_bad;

  // fixed priority: medium, track, sector, protection
  always_comb begin
    if (!present)               code = EC_NOMEDIA;
    else if (trk_bad)           code = EC_TRACK;
    else if (sec_bad)           code = EC_SECTOR;
    else if (is_write && wprot) code = EC_WPROT;
    else                        code = EC_NONE;
  end
endmodule

// File: rtl/fss_seek_timer.sv
module fss_seek_timer #(
  parameter int SEEK_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] gap,
  output logic       expired
);
  localparam int W = $clog2(SEEK_CYC * 256 + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= W'(SEEK_CYC) * W'(gap);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R3
  countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/fss_xfer.sv
module fss_xfer
  import fss_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              kill,
  input  logic              to_buf,
  input  logic [ADDR_W-1:0] base,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              buf_en,
  output logic              buf_we,
  output logic [IDX_W-1:0]  buf_idx,
  output logic [7:0]        buf_wdata,
  input  logic [7:0]        buf_rdata,
  output logic              done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BYTES - 1);

  logic             active_q, s2_vld_q;
  logic [IDX_W-1:0] cnt_q, s2_idx_q;
  logic [IDX_W:0]   beats_q;

  // stage 1 issues the source read, stage 2 writes the sink one cycle later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      s2_vld_q <= 1'b0;
      cnt_q    <= '0;
      s2_idx_q <= '0;
    end else if (kill) begin
      active_q <= 1'b0;
      s2_vld_q <= 1'b0;
    end else begin
      s2_vld_q <= active_q;
      s2_idx_q <= cnt_q;
      if (start) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end else if (active_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) active_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             beats_q <= '0;
    else if (start || kill) beats_q <= '0;
    else if (s2_vld_q)      beats_q <= beats_q + 1'b1;
  end

  assign done = s2_vld_q && (s2_idx_q == LAST);

  always_comb begin
    if (to_buf) begin
      mem_en    = active_q;
      mem_we    = 1'b0;
      mem_addr  = base + ADDR_W'(cnt_q);
      mem_wdata = 8'h00;
      buf_en    = s2_vld_q;
      buf_we    = s2_vld_q;
      buf_idx   = s2_idx_q;
      buf_wdata = mem_rdata;
    end else begin
      buf_en    = active_q;
      buf_we    = 1'b0;
      buf_idx   = cnt_q;
      buf_wdata = 8'h00;
      mem_en    = s2_vld_q;
      mem_we    = s2_vld_q;
      mem_addr  = base + ADDR_W'(s2_idx_q);
      mem_wdata = buf_rdata;
    end
  end

  // R1
  beat_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (beats_q == (IDX_W+1)'(BYTES - 1)));
  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active_q && !s2_vld_q);
endmodule

// File: rtl/flop_sect_seq.sv
module flop_sect_seq
  import fss_pkg::*;
#(
  parameter int SEEK_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_req,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_func,
  input  logic [DRV_W-1:0]  cmd_drive,
  input  logic [7:0]        cmd_track,
  input  logic [6:0]        cmd_sector,
  input  logic [DRIVES-1:0] drv_present,
  input  logic [DRIVES-1:0] drv_wprot,
  output logic              mem_en,
  output logic              mem_we,
  output logic [DRV_W-1:0]  mem_drive,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              buf_en,
  output logic              buf_we,
  output logic [IDX_W-1:0]  buf_idx,
  output logic [7:0]        buf_wdata,
  input  logic [7:0]        buf_rdata,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [7:0]        status,
  output logic [7:0]        err_code
);
  typedef enum logic [1:0] {S_IDLE, S_SEEK, S_XFER} st_e;

  st_e              st_q;
  op_e              op_q;
  logic [DRV_W-1:0] drv_q;
  logic [7:0]       trk_q;
  logic [6:0]       sec_q;
  logic             init_q;
  logic [7:0]       head_q [DRIVES];
  logic [7:0]       status_q, err_q;
  logic             fail_q, done_q;

  // named internal events
  op_e        cmd_op;
  logic       start_init, start_cmd, seek_load, seek_expired, seek_done;
  logic       xfer_start, xfer_done, finish, chk_trk_ok, fin_fail;
  logic [7:0] seek_gap, chk_code, fin_code, fin_flags;
  logic [ADDR_W-1:0] base;

  assign cmd_op     = op_e'(cmd_func);
  assign start_init = init_req;
  assign start_cmd  = !init_req && cmd_valid && (st_q == S_IDLE) && (cmd_op != OP_NONE);
  assign seek_load  = start_init || start_cmd;
  assign seek_gap   = start_init ? track_gap(head_q[0], 8'd1)
                                 : track_gap(head_q[cmd_drive], cmd_track);

  fss_seek_timer #(.SEEK_CYC(SEEK_CYC)) u_seek (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (seek_load),
    .gap     (seek_gap),
    .expired (seek_expired)
  );

  assign seek_done = !init_req && (st_q == S_SEEK) && seek_expired;

  fss_addr_check u_chk (
    .present  (drv_present[drv_q]),
    .wprot    (drv_wprot[drv_q]),
    .is_write (op_q != OP_READ),
    .trk      (trk_q),
    .sec      (sec_q),
    .code     (chk_code),
    .trk_ok   (chk_trk_ok)
  );

  assign xfer_start = seek_done && (init_q ? drv_present[0] : (chk_code == EC_NONE));
  assign base       = sector_base(trk_q, sec_q);

  fss_xfer u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (xfer_start),
    .kill      (init_req),
    .to_buf    (op_q == OP_READ),
    .base      (base),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .buf_en    (buf_en),
    .buf_we    (buf_we),
    .buf_idx   (buf_idx),
    .buf_wdata (buf_wdata),
    .buf_rdata (buf_rdata),
    .done      (xfer_done)
  );

  // completion decode
  always_comb begin
    finish    = 1'b0;
    fin_fail  = 1'b0;
    fin_code  = EC_NONE;
    fin_flags = 8'h00;
    if (seek_done && !xfer_start) begin
      finish   = 1'b1;
      fin_fail = 1'b1;
      if (init_q) begin
        fin_code  = EC_INIT0;
        fin_flags = ST_INIT;
      end else begin
        fin_code  = chk_code;
        fin_flags = (chk_code == EC_WPROT) ? ST_WLK : 8'h00;
      end
    end else if (!init_req && (st_q == S_XFER) && xfer_done) begin
      finish = 1'b1;
      if (init_q) begin
        fin_flags = ST_INIT;
        fin_code  = drv_present[DRIVES-1] ? EC_NONE : EC_INIT1;
      end else begin
        fin_flags = (op_q == OP_WRDEL) ? ST_DEL : 8'h00;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      op_q     <= OP_READ;
      drv_q    <= '0;
      trk_q    <= '0;
      sec_q    <= '0;
      init_q   <= 1'b0;
      status_q <= '0;
      err_q    <= '0;
      fail_q   <= 1'b0;
      done_q   <= 1'b0;
      for (int d = 0; d < DRIVES; d++) head_q[d] <= '0;
    end else begin
      done_q <= finish;
      if (start_init) begin
        st_q     <= S_SEEK;
        init_q   <= 1'b1;
        op_q     <= OP_READ;
        drv_q    <= '0;
        trk_q    <= 8'd1;
        sec_q    <= 7'd1;
        status_q <= '0;
        err_q    <= '0;
        fail_q   <= 1'b0;
      end else if (start_cmd) begin
        st_q     <= S_SEEK;
        init_q   <= 1'b0;
        op_q     <= cmd_op;
        drv_q    <= cmd_drive;
        trk_q    <= cmd_track;
        sec_q    <= cmd_sector;
        status_q <= status_q & ST_INIT;
      end else begin
        if (seek_done) begin
          if (init_q) begin
            for (int d = 0; d < DRIVES; d++) head_q[d] <= (d == 0) ? 8'd1 : 8'd0;
          end else if (chk_trk_ok) begin
            head_q[drv_q] <= trk_q;
          end
          if (xfer_start) st_q <= S_XFER;
        end
        if (finish) begin
          st_q     <= S_IDLE;
          status_q <= ((status_q | fin_flags) & ~ST_RDY) |
                      (drv_present[drv_q] ? ST_RDY : 8'h00);
          err_q    <= fin_code;
          fail_q   <= fin_fail;
        end
      end
    end
  end

  assign mem_drive = drv_q;
  assign busy      = (st_q != S_IDLE);
  assign done      = done_q;
  assign fail      = fail_q;
  assign status    = status_q;
  assign err_code  = err_q;

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid && !init_req) |=> $stable(trk_q) && $stable(drv_q) && $stable(sec_q));
  // R4
  wlk_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == EC_WPROT) |-> status[3]);
  // R1
  mem_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (int'(mem_addr) < TRACKS * SECTORS * BYTES));
  // R4
  mem_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en || buf_en) |-> (st_q == S_XFER));
  // R6
  ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (status[7] == $past(drv_present[drv_q])));
  // R3
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seek_done |=> $stable(head_q[0]));
endmodule

// File: tb/sim_flop_sect_seq.sv
`timescale 1ns/1ps
module sim_flop_sect_seq;
  import fss_pkg::*;

  localparam int SC = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              init_req = 1'b0;
  logic              cmd_valid = 1'b0;
  logic [1:0]        cmd_func = 2'd0;
  logic [DRV_W-1:0]  cmd_drive = '0;
  logic [7:0]        cmd_track = '0;
  logic [6:0]        cmd_sector = '0;
  logic [DRIVES-1:0] drv_present = '1;
  logic [DRIVES-1:0] drv_wprot = '0;
  logic              mem_en, mem_we, buf_en, buf_we, busy, done, fail;
  logic [DRV_W-1:0]  mem_drive;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_wdata, buf_wdata, status, err_code;
  logic [7:0]        mem_rdata = 8'h00;
  logic [7:0]        buf_rdata = 8'h00;
  logic [IDX_W-1:0]  buf_idx;

  always #2.5 clk = ~clk;

  flop_sect_seq #(.SEEK_CYC(SC)) u0 (.*);

  int checks = 0;
  int failures = 0;

  function automatic logic [7:0] pat(input logic drv, input int a);
    return 8'(a) ^ 8'(a >>> 8) ^ 8'(a >>> 16) ^ (drv ? 8'hA5 : 8'h3C);
  endfunction

  function automatic int lin(input int t, input int s);
    return (t * 26 + s - 1) * 128;
  endfunction

  // memory, buffer and activity models
  logic [7:0] bbuf [128];
  int wlog_addr [128];
  logic [7:0] wlog_data [128];
  logic wlog_drv [128];
  int wr_total = 0, rd_total = 0, buf_total = 0;

  always @(posedge clk) begin
    if (mem_en && !mem_we) begin
      mem_rdata <= pat(mem_drive[0], int'(mem_addr));
      rd_total  <= rd_total + 1;
    end
    if (mem_en && mem_we) begin
      wlog_addr[wr_total % 128] <= int'(mem_addr);
      wlog_data[wr_total % 128] <= mem_wdata;
      wlog_drv[wr_total % 128]  <= mem_drive[0];
      wr_total <= wr_total + 1;
    end
    if (buf_en && buf_we) bbuf[buf_idx] <= buf_wdata;
    if (buf_en && !buf_we) buf_rdata <= bbuf[buf_idx];
    if (buf_en) buf_total <= buf_total + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0o expected=%0o", tag, act, exp);
    end
  endtask

  task automatic wait_done(output int lat);
    lat = 1;
    while (!done && lat < 5000) begin
      @(negedge clk);
      lat++;
    end
    check(done === 1'b1, "R11 completion seen", int'(done), 1);
    @(negedge clk);
    check(done === 1'b0, "R11 done one cycle", int'(done), 0);
  endtask

  task automatic run_cmd(input int f, input int d, input int t, input int s, output int lat);
    @(negedge clk);
    cmd_func = 2'(f); cmd_drive = DRV_W'(d); cmd_track = 8'(t); cmd_sector = 7'(s);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done(lat);
  endtask

  task automatic do_init(output int lat);
    @(negedge clk);
    init_req = 1'b1;
    @(negedge clk);
    init_req = 1'b0;
    wait_done(lat);
  endtask

  task automatic check_buf(input int d, input int t, input int s, input string tag);
    int bad = 0;
    for (int i = 0; i < 128; i++)
      if (bbuf[i] !== pat(d[0], lin(t, s) + i)) bad++;
    check(bad == 0, tag, bad, 0);
  endtask

  task automatic check_result(input int code, input int st, input bit f, input string tag);
    check(err_code == 8'(code), {tag, " code"}, int'(err_code), code);
    check(status == 8'(st), {tag, " status"}, int'(status), st);
    check(fail == f, {tag, " fail"}, int'(fail), int'(f));
  endtask

  int L0;

  task automatic t_reset();
    check(busy == 0 && done == 0, "R12 busy/done", int'({busy, done}), 0);
    check(status == 0 && err_code == 0 && fail == 0, "R12 status/code",
          int'({fail, status, err_code}), 0);
  endtask

  task automatic t_init_ok();
    int lat, rd0;
    rd0 = rd_total;
    do_init(lat);
    check_result(8'o000, 8'o204, 1'b0, "R8 init");
    check(rd_total - rd0 == 128, "R8 init reads", rd_total - rd0, 128);
    check_buf(0, 1, 1, "R8 init loads t1 s1");
  endtask

  task automatic t_seek();
    int lat;
    run_cmd(0, 0, 1, 1, L0);
    run_cmd(0, 1, 0, 4, lat);
    check(lat == L0, "R8 drive1 parked on track 0", lat, L0);
    run_cmd(0, 0, 11, 2, lat);
    check(lat == L0 + 10 * SC, "R3 seek out 10", lat, L0 + 10 * SC);
    run_cmd(0, 0, 11, 3, lat);
    check(lat == L0, "R3 no seek same track", lat, L0);
    run_cmd(0, 0, 4, 3, lat);
    check(lat == L0 + 7 * SC, "R3 seek back 7", lat, L0 + 7 * SC);
    run_cmd(0, 0, 120, 1, lat);
    check(err_code == 8'o040, "R3 bad track rejected", int'(err_code), 8'o040);
    run_cmd(0, 0, 4, 5, lat);
    check(lat == L0, "R3 head unmoved by bad track", lat, L0);
  endtask

  task automatic t_read();
    int lat;
    run_cmd(0, 0, 5, 3, lat);
    check_result(0, 8'o204, 1'b0, "R1 read");
    check_buf(0, 5, 3, "R1 read data t5 s3");
    run_cmd(0, 1, 76, 26, lat);
    check_result(0, 8'o204, 1'b0, "R1 last sector");
    check_buf(1, 76, 26, "R1 read data d1 t76 s26");
  endtask

  task automatic t_write(input int f, input int d, input int t, input int s,
                         input int st, input string tag);
    int lat, w0, bad;
    run_cmd(0, 0, 5, 3, lat);
    w0 = wr_total;
    run_cmd(f, d, t, s, lat);
    check_result(0, st, 1'b0, tag);
    check(wr_total - w0 == 128, {tag, " write count"}, wr_total - w0, 128);
    bad = 0;
    for (int i = 0; i < 128; i++) begin
      int k = (w0 + i) % 128;
      if (wlog_addr[k] != lin(t, s) + i || wlog_data[k] !== pat(1'b0, lin(5, 3) + i) ||
          wlog_drv[k] !== d[0]) bad++;
    end
    check(bad == 0, {tag, " write data"}, bad, 0);
  endtask

  task automatic t_err(input int f, input int d, input int t, input int s,
                       input int code, input int st, input string tag);
    int lat, r0, w0;
    r0 = rd_total; w0 = wr_total;
    run_cmd(f, d, t, s, lat);
    check_result(code, st, 1'b1, tag);
    check(rd_total == r0 && wr_total == w0, {tag, " no access"}, rd_total - r0 + wr_total - w0, 0);
  endtask

  task automatic t_errors();
    int lat;
    t_err(0, 0, 77, 1, 8'o040, 8'o204, "R4 track 77");
    t_err(0, 0, 3, 0, 8'o070, 8'o204, "R4 sector 0");
    t_err(0, 0, 3, 27, 8'o070, 8'o204, "R4 sector 27");
    drv_present = 2'b01;
    t_err(0, 1, 3, 3, 8'o110, 8'o004, "R4 no medium");
    t_err(0, 1, 90, 0, 8'o110, 8'o004, "R5 medium before track");
    drv_present = 2'b11; drv_wprot = 2'b10;
    t_err(1, 1, 80, 0, 8'o040, 8'o204, "R5 track before sector");
    t_err(1, 1, 5, 27, 8'o070, 8'o204, "R5 sector before protect");
    t_err(1, 1, 5, 5, 8'o100, 8'o214, "R4 protected write");
    t_err(2, 1, 5, 6, 8'o100, 8'o214, "R7 protected write-deleted");
    run_cmd(0, 1, 5, 5, lat);
    check_result(0, 8'o204, 1'b0, "R6 read clears protect flag");
    drv_wprot = 2'b00;
  endtask

  task automatic t_ignore();
    int lat, w0, d0, extra;
    w0 = wr_total; d0 = 0;
    @(negedge clk);
    cmd_func = 2'd0; cmd_drive = '0; cmd_track = 8'd2; cmd_sector = 7'd4; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (40) @(negedge clk);
    cmd_func = 2'd1; cmd_drive = 1'b1; cmd_track = 8'd9; cmd_sector = 7'd9; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done(lat);
    extra = 0;
    repeat (200) begin
      @(negedge clk);
      if (done || busy) extra++;
    end
    check(extra == 0, "R10 busy command dropped", extra, 0);
    check(wr_total == w0, "R10 no write from dropped command", wr_total - w0, 0);
    check_buf(0, 2, 4, "R10 original read intact");
    @(negedge clk);
    cmd_func = 2'd3; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (40) begin
      @(negedge clk);
      if (done || busy) d0++;
    end
    check(d0 == 0, "R10 function 3 ignored", d0, 0);
  endtask

  task automatic t_init_missing();
    int lat, r0;
    drv_present = 2'b10;
    r0 = rd_total;
    do_init(lat);
    check_result(8'o010, 8'o004, 1'b1, "R9 drive0 absent");
    check(rd_total == r0, "R9 no access", rd_total - r0, 0);
    drv_present = 2'b01;
    do_init(lat);
    check_result(8'o020, 8'o204, 1'b0, "R8 drive1 absent");
    check_buf(0, 1, 1, "R8 load with drive1 absent");
    drv_present = 2'b11;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    fork
      begin
        t_init_ok();
        t_seek();
        t_read();
        t_write(1, 1, 76, 26, 8'o204, "R2 write");
        t_write(2, 1, 0, 1, 8'o304, "R7 write-deleted");
        t_write(1, 0, 40, 13, 8'o204, "R6 write after deleted clears flag");
        t_errors();
        t_ignore();
        t_init_missing();
      end
      begin
        repeat (190000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule